// File: doc/BRIEF.md
# Reset Release and Clock Source Sequencer

This block decides when the internal system reset is let go after a reset request, which 3-bit oscillator selection code is loaded for that reset, and when code execution and the clock-failure monitor may start. It runs from a free-running reference clock, and every delay is a parameter counted in cycles of that clock. The analog detectors and the oscillators are outside the block. Their outcomes arrive as a reset-request pulse with a 3-bit reason code and as a single oscillator-ready level, which means the oscillator is running and the PLL is locked.

The reset delay and the oscillator start-up count begin together on the same request edge. Neither waits for the other. Execution is enabled when both have finished. The clock-failure monitor is enabled a fixed number of cycles after the system reset is released. The local synchronous reset `rst` counts as a power-on request. Any later request restarts the whole sequence.

Reason codes on `req_kind`: 0 power-on, 1 brown-out, 2 external pin, 3 watchdog, 4 software. Codes 5 to 7 are handled like the non-supply kinds (2 to 4).

Top module: `rst_clk_sequencer`

## Requirements
- R1: While `rst` is high and at the edge after it, `sys_rst` is 1, `exec_en` and `mon_en` are 0, and `osc_sel` holds the `cfg_osc` value present at the last `rst` edge.
- R2: With `clk_sw_en` = 0, a request of any reason code loads `cfg_osc` into `osc_sel` at the request edge.
- R3: With `clk_sw_en` = 1, a power-on (0) or brown-out (1) request loads `cfg_osc` into `osc_sel`.
- R4: With `clk_sw_en` = 1, a request with code 2, 3, 4 or 5..7 loads `cur_osc` into `osc_sel`.
- R5: For codes 0 and 1 (and for `rst`), `sys_rst` falls exactly `POR_CYC + PWRT_CYC` reference edges after the request edge.
- R6: For all other codes, `sys_rst` falls exactly `SHORT_CYC` edges after the request edge.
- R7: The oscillator wait starts at the request edge, in parallel with the reset delay. It completes after `OST_CYC` consecutive edges with `osc_ready` high. A low `osc_ready` before completion restarts the count.
- R8: `exec_en` is 1 only while `sys_rst` is 0 and the oscillator wait is complete. It rises on the edge where the later of the two finishes.
- R9: `mon_en` rises exactly `MON_CYC` edges after the edge at which `sys_rst` fell, and is never 1 while `sys_rst` is 1.
- R10: A request arriving in any phase drives `sys_rst` to 1 and `exec_en` and `mon_en` to 0 at its own edge. All delays then count again from that edge.
- R11: Between requests, `osc_sel` stays constant whatever `cfg_osc`, `cur_osc` and `clk_sw_en` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset, treated as a power-on request |
| req_valid | input | 1 | One-cycle reset request pulse |
| req_kind | input | 3 | Reason code of the request |
| clk_sw_en | input | 1 | Clock-switching enable configuration bit |
| cfg_osc | input | 3 | Configured oscillator selection code |
| cur_osc | input | 3 | Oscillator code currently in use |
| osc_ready | input | 1 | Oscillator running and PLL locked |
| sys_rst | output | 1 | Internal system reset, active high |
| osc_sel | output | 3 | Oscillator code loaded at the last request |
| exec_en | output | 1 | Code execution may begin |
| mon_en | output | 1 | Clock-failure monitor enabled |

## Verification
`osc_sel`, `sys_rst`, `exec_en` and `mon_en` all change on the request edge itself. After that:
- `sys_rst` falls D edges later, where D is 24 or 4 with the default parameters.
- `exec_en` rises at the later of the release edge and the `OST_CYC`-th ready edge.
- `mon_en` rises `MON_CYC` edges after the release.

The bench samples 1 ns after each rising edge. For every such output it checks the value one edge before the due edge and again at the due edge, so a result that arrives one cycle early or late is caught.

// File: rtl/rst_clk_seq_pkg.sv
package rst_clk_seq_pkg;

    typedef enum logic [2:0] {
        RK_POWER    = 3'd0,
        RK_BROWN    = 3'd1,
        RK_PIN      = 3'd2,
        RK_WATCHDOG = 3'd3,
        RK_SOFT     = 3'd4
    } rrs_kind_e;

    typedef struct packed {
        logic [2:0] kind;
        logic [2:0] osc;
    } rrs_event_t;

    function automatic logic is_supply_kind(input logic [2:0] k);
        return (k == RK_POWER) || (k == RK_BROWN);
    endfunction

    function automatic logic [2:0] pick_osc(input logic sw_en, input logic [2:0] k,
                                            input logic [2:0] cfg, input logic [2:0] cur);
        if (!sw_en || is_supply_kind(k)) return cfg;
        return cur;
    endfunction

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/rrs_span_timer.sv
module rrs_span_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          done
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (run && !done) begin
            if (cnt == limit - CW'(1)) done <= 1'b1;
            else                       cnt  <= cnt + CW'(1);
        end
    end

    // R7: completion is sticky until restarted
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !restart) |=> done);

    // R5: the running count never passes the terminal value
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (!done && !restart) |=> (cnt < limit));

endmodule

// File: rtl/rrs_event_latch.sv
module rrs_event_latch
    import rst_clk_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [2:0] req_kind,
    input  logic       clk_sw_en,
    input  logic [2:0] cfg_osc,
    input  logic [2:0] cur_osc,
    output rrs_event_t ev_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_q.kind <= RK_POWER;
            ev_q.osc  <= cfg_osc;
        end else if (req_valid) begin
            ev_q.kind <= req_kind;
            ev_q.osc  <= pick_osc(clk_sw_en, req_kind, cfg_osc, cur_osc);
        end
    end

    // R2: switching disabled always loads the configured code
    p_sel_cfg_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !clk_sw_en) |=> (ev_q.osc == $past(cfg_osc)));

    // R4: non-supply kinds with switching keep the current code
    p_sel_cur_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && clk_sw_en && (req_kind > 3'd1)) |=> (ev_q.osc == $past(cur_osc)));

endmodule

// File: rtl/rst_clk_sequencer.sv
module rst_clk_sequencer
    import rst_clk_seq_pkg::*;
#(
    parameter int POR_CYC   = 8,
    parameter int PWRT_CYC  = 16,
    parameter int SHORT_CYC = 4,
    parameter int OST_CYC   = 12,
    parameter int MON_CYC   = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [2:0] req_kind,
    input  logic       clk_sw_en,
    input  logic [2:0] cfg_osc,
    input  logic [2:0] cur_osc,
    input  logic       osc_ready,
    output logic       sys_rst,
    output logic [2:0] osc_sel,
    output logic       exec_en,
    output logic       mon_en
);

    localparam int LONG_CYC = POR_CYC + PWRT_CYC;
    localparam int MAX_CYC  = max_of4(LONG_CYC, SHORT_CYC, OST_CYC, MON_CYC);
    localparam int CW       = $clog2(MAX_CYC + 1);

    rrs_event_t    ev_q;
    logic [CW-1:0] rel_limit;
    logic          rel_done;
    logic          osc_done;
    logic          mon_done;
    logic          osc_restart;

    rrs_event_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .clk_sw_en (clk_sw_en),
        .cfg_osc   (cfg_osc),
        .cur_osc   (cur_osc),
        .ev_q      (ev_q)
    );

    always_comb begin
        rel_limit = is_supply_kind(ev_q.kind) ? CW'(LONG_CYC) : CW'(SHORT_CYC);
    end

    rrs_span_timer #(.CW(CW)) u_rel (
        .clk     (clk),
        .rst     (rst),
        .restart (req_valid),
        .run     (1'b1),
        .limit   (rel_limit),
        .done    (rel_done)
    );

    assign osc_restart = req_valid || (!osc_ready && !osc_done);

    rrs_span_timer #(.CW(CW)) u_ost (
        .clk     (clk),
        .rst     (rst),
        .restart (osc_restart),
        .run     (osc_ready),
        .limit   (CW'(OST_CYC)),
        .done    (osc_done)
    );

    rrs_span_timer #(.CW(CW)) u_mon (
        .clk     (clk),
        .rst     (rst),
        .restart (req_valid),
        .run     (rel_done),
        .limit   (CW'(MON_CYC)),
        .done    (mon_done)
    );

    assign sys_rst = !rel_done;
    assign osc_sel = ev_q.osc;
    assign exec_en = rel_done && osc_done;
    assign mon_en  = mon_done;

    // R9: monitor never runs while the system is held in reset
    p_mon_after_release_r9: assert property (@(posedge clk) disable iff (rst)
        mon_en |-> !sys_rst);

    // R10: a request drops everything back into reset at its edge
    p_restart_all_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (sys_rst && !exec_en && !mon_en));

    // R11: selection is held between requests
    p_sel_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(osc_sel));

    // R8: execution starts only once reset has been let go
    p_exec_released_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(exec_en) |-> !sys_rst);

endmodule

// File: tb/rst_clk_sequencer_tb.sv
module rst_clk_sequencer_tb;

    localparam int LONG  = 24;
    localparam int SHORT = 4;
    localparam int OST   = 12;
    localparam int MON   = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] req_kind = 3'd0;
    logic       clk_sw_en = 1'b1;
    logic [2:0] cfg_osc = 3'b010;
    logic [2:0] cur_osc = 3'b101;
    logic       osc_ready = 1'b1;
    logic       sys_rst;
    logic [2:0] osc_sel;
    logic       exec_en;
    logic       mon_en;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rst_clk_sequencer u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .clk_sw_en(clk_sw_en), .cfg_osc(cfg_osc), .cur_osc(cur_osc),
        .osc_ready(osc_ready), .sys_rst(sys_rst), .osc_sel(osc_sel),
        .exec_en(exec_en), .mon_en(mon_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic issue(input logic [2:0] k);
        @(negedge clk);
        req_kind  = k;
        req_valid = 1'b1;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    // checks a 0->1 or 1->0 edge lands exactly n edges after now
    task automatic expect_change(input string tag, input int n, ref logic sig, input logic after);
        edges(n - 1);
        chk(tag, sig, !after);
        edges(1);
        chk(tag, sig, after);
    endtask

    task automatic t_power_on();
        rst = 1'b1;
        edges(3);
        rst = 1'b0;
        chk("R1 sys_rst", sys_rst, 1);
        chk("R1 exec_en", exec_en, 0);
        chk("R1 mon_en", mon_en, 0);
        chk("R1 osc_sel", osc_sel, 3'b010);
        expect_change("R5 power-on release", LONG, sys_rst, 1'b0);
        chk("R8 exec at release", exec_en, 1);
        expect_change("R9 monitor delay", MON, mon_en, 1'b1);
    endtask

    task automatic t_switch_off();
        clk_sw_en = 1'b0;
        cfg_osc = 3'b001; cur_osc = 3'b110;
        issue(3'd2);
        chk("R2 pin keeps cfg", osc_sel, 3'b001);
        expect_change("R6 short release", SHORT, sys_rst, 1'b0);
        issue(3'd3);
        chk("R2 watchdog cfg", osc_sel, 3'b001);
        clk_sw_en = 1'b1;
    endtask

    task automatic t_supply_switch_on();
        cfg_osc = 3'b011; cur_osc = 3'b111;
        issue(3'd1);
        chk("R3 brown-out cfg", osc_sel, 3'b011);
        expect_change("R5 brown-out release", LONG, sys_rst, 1'b0);
        issue(3'd0);
        chk("R3 power-on cfg", osc_sel, 3'b011);
    endtask

    task automatic t_keep_current();
        cfg_osc = 3'b000; cur_osc = 3'b100;
        issue(3'd3);
        chk("R4 watchdog cur", osc_sel, 3'b100);
        cur_osc = 3'b110;
        issue(3'd6);
        chk("R4 code 6 cur", osc_sel, 3'b110);
        cur_osc = 3'b101;
        issue(3'd4);
        chk("R4 software cur", osc_sel, 3'b101);
        expect_change("R6 software release", SHORT, sys_rst, 1'b0);
        chk("R8 exec waits for osc", exec_en, 0);
        expect_change("R8 exec at osc done", OST - SHORT, exec_en, 1'b1);
    endtask

    task automatic t_osc_wait();
        osc_ready = 1'b0;
        issue(3'd4);
        expect_change("R6 release w/o osc", SHORT, sys_rst, 1'b0);
        edges(20);
        chk("R7 no ready no exec", exec_en, 0);
        osc_ready = 1'b1;
        edges(5);
        osc_ready = 1'b0;
        edges(1);
        osc_ready = 1'b1;
        expect_change("R7 restarted osc count", OST, exec_en, 1'b1);
    endtask

    task automatic t_restart();
        issue(3'd4);
        edges(SHORT + 2);
        chk("R10 released before", sys_rst, 0);
        issue(3'd1);
        chk("R10 sys_rst again", sys_rst, 1);
        chk("R10 exec dropped", exec_en, 0);
        chk("R10 mon dropped", mon_en, 0);
        expect_change("R10 new delay", LONG, sys_rst, 1'b0);
    endtask

    task automatic t_hold();
        logic [2:0] held;
        held = osc_sel;
        cfg_osc = ~cfg_osc; cur_osc = ~cur_osc; clk_sw_en = ~clk_sw_en;
        edges(5);
        chk("R11 osc_sel held", osc_sel, held);
        clk_sw_en = 1'b1;
    endtask

    initial begin
        #1;
        t_power_on();
        t_switch_off();
        t_supply_switch_on();
        t_keep_current();
        t_osc_wait();
        t_restart();
        t_hold();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule